// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 64-bit virtual address into a physical page number by walking a radix tree of four table levels held in memory. Pages are 8 KB, so the low 13 bits of the address are the page offset, and above that four 10-bit fields each select one 8-byte entry in a table of 1024 entries. The top 11 bits of every legal virtual address must be zero. An address that breaks this rule is refused at once, with no memory traffic.

A requester offers a virtual address and the physical byte address of the top-level table over a valid/ready handshake. The walker then issues one memory read per level, one at a time. It uses the page number in each intermediate entry, shifted up by 13 bits, as the base of the next table. It returns the final page number with its read, write and execute permission bits. If any entry on the way has its valid bit clear, it returns a fault that names the level. Only one walk is in progress at a time. The request side stays closed until the response has been taken.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_rd_valid is 0.
- R2: A request whose vaddr[63:53] is nonzero produces a response with rsp_fault=1, rsp_fault_cause=0, rsp_fault_level=0, rsp_ppn=0 and all permission outputs 0. No memory read is issued for it.
- R3: The first read goes to req_root + 8*vaddr[52:43], in 43-bit arithmetic. The indices for the later levels are vaddr[42:33], vaddr[32:23] and vaddr[22:13], in that order.
- R4: Each read after the first goes to {ppn of the previous entry, 13'b0} + 8*index of the current level.
- R5: Entry fields are valid at bit 0, execute at bit 1, write at bit 2, read at bit 3, and the page number at bits 42:13. All other bits are ignored.
- R6: An entry with bit 0 clear at level k (k=0 for the first level up to k=3 for the last) ends the walk with rsp_fault=1, rsp_fault_cause=1 and rsp_fault_level=k. rsp_ppn and the permission outputs are 0. Exactly k+1 reads are issued for that walk.
- R7: A walk that finds every entry valid issues exactly four reads. It responds with rsp_fault=0, rsp_ppn equal to the page number of the fourth entry, and rsp_read, rsp_write and rsp_exec equal to that entry's permission bits.
- R8: From the accepted request until the accepted response, req_ready stays 0. While rsp_valid=1 and rsp_ready=0, the response stays valid and unchanged.
- R9: While mem_rd_valid=1 and mem_rd_ready=0, the read request stays valid and mem_rd_addr does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 43 | Physical byte address of the top-level table |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 43 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned, one pulse per read |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Walk result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Walk failed |
| rsp_fault_cause | output | 1 | 0: address upper bits nonzero, 1: invalid entry |
| rsp_fault_level | output | 2 | Level of the invalid entry (0 = first) |
| rsp_ppn | output | 30 | Translated physical page number |
| rsp_read | output | 1 | Read permission of the final entry |
| rsp_write | output | 1 | Write permission of the final entry |
| rsp_exec | output | 1 | Execute permission of the final entry |

## Verification
The assertions assume that memory answers each accepted read with exactly one single-cycle mem_rsp_valid pulse. They also assume that the pulse never comes when no read is outstanding, since the read counts they compare against depend on it. The bench's memory model keeps to this contract. It waits for the handshake, adds a random delay of zero to two cycles, and drives one data pulse before it looks at the next read request. It also throttles mem_rd_ready and rsp_ready at random, which exercises the hold rules, but it never breaks the one-read-outstanding discipline.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W      = 64;
    localparam int ZERO_W    = 11;
    localparam int IDX_W     = 10;
    localparam int LEVELS    = 4;
    localparam int OFF_W     = 13;
    localparam int PPN_W     = 30;
    localparam int PTE_W     = 64;
    localparam int PTE_LG    = 3;
    localparam int PA_W      = PPN_W + OFF_W;
    localparam int LVL_W     = $clog2(LEVELS);

    localparam int BIT_V     = 0;
    localparam int BIT_X     = 1;
    localparam int BIT_W     = 2;
    localparam int BIT_R     = 3;
    localparam int PPN_LSB   = 13;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } walk_state_e;

    typedef enum logic {
        FLT_RANGE   = 1'b0,
        FLT_INVALID = 1'b1
    } fault_cause_e;

    typedef logic [LEVELS-1:0][IDX_W-1:0] idx_vec_t;

    typedef struct packed {
        logic             valid;
        logic             exec;
        logic             write;
        logic             read;
        logic [PPN_W-1:0] ppn;
    } pte_fields_t;

    typedef struct packed {
        logic             fault;
        fault_cause_e     cause;
        logic [LVL_W-1:0] level;
        logic [PPN_W-1:0] ppn;
        logic             read;
        logic             write;
        logic             exec;
    } walk_result_t;

    function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0]  base,
                                                   input logic [IDX_W-1:0] idx);
        return base + {{(PA_W-IDX_W-PTE_LG){1'b0}}, idx, {PTE_LG{1'b0}}};
    endfunction

    function automatic walk_result_t make_fault(input fault_cause_e     cause,
                                                input logic [LVL_W-1:0] level);
        walk_result_t r;
        r       = '0;
        r.fault = 1'b1;
        r.cause = cause;
        r.level = level;
        return r;
    endfunction

    function automatic walk_result_t make_ok(input pte_fields_t e);
        walk_result_t r;
        r       = '0;
        r.ppn   = e.ppn;
        r.read  = e.read;
        r.write = e.write;
        r.exec  = e.exec;
        return r;
    endfunction

endpackage

// File: rtl/ptw_vaddr_split.sv
module ptw_vaddr_split
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    output logic            upper_ok,
    output idx_vec_t        idx
);
    localparam int TOP_LSB = VA_W - ZERO_W;

    assign upper_ok = (vaddr[VA_W-1:TOP_LSB] == '0);

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        // level 0 takes the highest index field
        assign idx[g] = vaddr[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
    end

    logic unused_offset;
    assign unused_offset = ^vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    output pte_fields_t      fields
);
    assign fields.valid = pte[BIT_V];
    assign fields.exec  = pte[BIT_X];
    assign fields.write = pte[BIT_W];
    assign fields.read  = pte[BIT_R];
    assign fields.ppn   = pte[PPN_LSB +: PPN_W];

    logic unused_rsvd;
    assign unused_rsvd = ^{pte[PTE_W-1:PPN_LSB+PPN_W], pte[PPN_LSB-1:BIT_R+1]};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_upper_ok,
    input  idx_vec_t        req_idx,
    input  logic [PA_W-1:0] req_root,
    output logic            mem_rd_valid,
    input  logic            mem_rd_ready,
    output logic [PA_W-1:0] mem_rd_addr,
    input  logic            mem_rsp_valid,
    input  pte_fields_t     entry,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output walk_result_t    result
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);

    walk_state_e      state_q;
    logic [LVL_W-1:0] level_q;
    logic [PA_W-1:0]  base_q;
    idx_vec_t         idx_q;
    walk_result_t     res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            level_q <= '0;
            base_q  <= '0;
            idx_q   <= '0;
            res_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        idx_q   <= req_idx;
                        base_q  <= req_root;
                        level_q <= '0;
                        if (!req_upper_ok) begin
                            res_q   <= make_fault(FLT_RANGE, '0);
                            state_q <= ST_RESP;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (mem_rd_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!entry.valid) begin
                            res_q   <= make_fault(FLT_INVALID, level_q);
                            state_q <= ST_RESP;
                        end else if (level_q == LAST_LVL) begin
                            res_q   <= make_ok(entry);
                            state_q <= ST_RESP;
                        end else begin
                            base_q  <= {entry.ppn, {OFF_W{1'b0}}};
                            level_q <= level_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign mem_rd_valid = (state_q == ST_ISSUE);
    assign mem_rd_addr  = entry_addr(base_q, idx_q[level_q]);
    assign rsp_valid    = (state_q == ST_RESP);
    assign result       = res_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  req_root,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic             rsp_fault,
    output logic             rsp_fault_cause,
    output logic [LVL_W-1:0] rsp_fault_level,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             rsp_read,
    output logic             rsp_write,
    output logic             rsp_exec
);
    logic         upper_ok;
    idx_vec_t     idx;
    pte_fields_t  entry;
    walk_result_t result;

    ptw_vaddr_split i_split (
        .vaddr    (req_vaddr),
        .upper_ok (upper_ok),
        .idx      (idx)
    );

    ptw_entry_decode i_decode (
        .pte    (mem_rsp_data),
        .fields (entry)
    );

    ptw_ctrl i_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_upper_ok  (upper_ok),
        .req_idx       (idx),
        .req_root      (req_root),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .entry         (entry),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .result        (result)
    );

    assign rsp_fault       = result.fault;
    assign rsp_fault_cause = result.cause;
    assign rsp_fault_level = result.level;
    assign rsp_ppn         = result.ppn;
    assign rsp_read        = result.read;
    assign rsp_write       = result.write;
    assign rsp_exec        = result.exec;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_rd_valid,
    input logic             mem_rd_ready,
    input logic [PA_W-1:0]  mem_rd_addr,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic             rsp_fault,
    input logic             rsp_fault_cause,
    input logic [LVL_W-1:0] rsp_fault_level,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic             rsp_read,
    input logic             rsp_write,
    input logic             rsp_exec
);
    logic [2:0] reads_q;

    always_ff @(posedge clk) begin
        if (rst)                           reads_q <= '0;
        else if (req_valid && req_ready)   reads_q <= '0;
        else if (mem_rd_valid && mem_rd_ready) reads_q <= reads_q + 3'd1;
    end

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);                                             // R8
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid &&
        $stable({rsp_fault, rsp_fault_cause, rsp_fault_level, rsp_ppn,
                 rsp_read, rsp_write, rsp_exec}));                             // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R9
    AST_RANGE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault && !rsp_fault_cause |-> reads_q == 3'd0);       // R2
    AST_FAULT_READS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault && rsp_fault_cause |->
        reads_q == {1'b0, rsp_fault_level} + 3'd1);                            // R6
    AST_FULL_WALK: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> reads_q == 3'd4);                          // R7
    AST_NO_READ_IN_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_rd_valid);                                          // R7
endmodule

bind pt_walker ptw_checker i_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .mem_rd_valid    (mem_rd_valid),
    .mem_rd_ready    (mem_rd_ready),
    .mem_rd_addr     (mem_rd_addr),
    .rsp_valid       (rsp_valid),
    .rsp_ready       (rsp_ready),
    .rsp_fault       (rsp_fault),
    .rsp_fault_cause (rsp_fault_cause),
    .rsp_fault_level (rsp_fault_level),
    .rsp_ppn         (rsp_ppn),
    .rsp_read        (rsp_read),
    .rsp_write       (rsp_write),
    .rsp_exec        (rsp_exec)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [42:0] req_root = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [42:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic        rsp_fault_cause;
    logic [1:0]  rsp_fault_level;
    logic [29:0] rsp_ppn;
    logic        rsp_read, rsp_write, rsp_exec;

    int checks = 0;
    int fails  = 0;
    logic [63:0] w_va;
    logic [42:0] w_root;
    logic [63:0] w_pte [4];
    int rd_count = 0;

    always #4 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_fault_cause(rsp_fault_cause),
        .rsp_fault_level(rsp_fault_level), .rsp_ppn(rsp_ppn),
        .rsp_read(rsp_read), .rsp_write(rsp_write), .rsp_exec(rsp_exec)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] idx_of(input logic [63:0] va, input int lvl);
        return va[13 + (3-lvl)*10 +: 10];
    endfunction

    function automatic logic [42:0] exp_addr(input int lvl);
        logic [42:0] base;
        if (lvl == 0) base = w_root;
        else          base = {w_pte[lvl-1][42:13], 13'b0};
        return base + {30'b0, idx_of(w_va, lvl), 3'b000};
    endfunction

    // memory model: one read outstanding, random accept and return delay
    initial begin
        bit          held = 0;
        logic [42:0] held_addr = '0;
        forever begin
            @(negedge clk);
            mem_rd_ready  = 1'b0;
            mem_rsp_valid = 1'b0;
            if (held) begin
                chk(mem_rd_valid === 1'b1, "R9", "read request held", {63'b0, mem_rd_valid}, 64'd1);
                chk(mem_rd_addr === held_addr, "R9", "read address held", {21'b0, mem_rd_addr}, {21'b0, held_addr});
                held = 0;
            end
            if (mem_rd_valid) begin
                if ($urandom % 4 != 0) begin
                    mem_rd_ready = 1'b1;
                    if (rd_count >= 4) begin
                        chk(0, "R7", "read count", rd_count, 4);
                    end else begin
                        chk(mem_rd_addr === exp_addr(rd_count), (rd_count == 0) ? "R3" : "R4",
                            "entry address", {21'b0, mem_rd_addr}, {21'b0, exp_addr(rd_count)});
                    end
                    rd_count++;
                    @(negedge clk);
                    mem_rd_ready = 1'b0;
                    repeat ($urandom % 3) @(negedge clk);
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = w_pte[(rd_count > 4) ? 3 : rd_count-1];
                    @(negedge clk);
                    mem_rsp_valid = 1'b0;
                end else begin
                    held      = 1;
                    held_addr = mem_rd_addr;
                end
            end
        end
    end

    task automatic run_walk(input logic [63:0] va, input logic [42:0] root,
                            input logic [63:0] p0, input logic [63:0] p1,
                            input logic [63:0] p2, input logic [63:0] p3);
        logic        e_fault, e_cause, e_r, e_w, e_x;
        logic [1:0]  e_lvl;
        logic [29:0] e_ppn;
        int          e_reads;
        string       tag;
        w_va = va; w_root = root;
        w_pte[0] = p0; w_pte[1] = p1; w_pte[2] = p2; w_pte[3] = p3;
        rd_count = 0;
        e_fault = 0; e_cause = 0; e_lvl = 0; e_ppn = '0; e_r = 0; e_w = 0; e_x = 0;
        if (va[63:53] != 0) begin
            e_fault = 1; e_reads = 0; tag = "R2";
        end else begin
            e_reads = 4; tag = "R7";
            for (int l = 3; l >= 0; l--) begin
                if (!w_pte[l][0]) begin
                    e_fault = 1; e_cause = 1; e_lvl = 2'(l); e_reads = l + 1; tag = "R6";
                end
            end
            if (!e_fault) begin
                e_ppn = p3[42:13]; e_r = p3[3]; e_w = p3[2]; e_x = p3[1];
            end
        end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_root = root;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) begin
            chk(req_ready === 1'b0, "R8", "ready low during walk", {63'b0, req_ready}, 64'd0);
            @(negedge clk);
        end
        repeat ($urandom % 3) begin
            chk(req_ready === 1'b0, "R8", "ready low while response waits", {63'b0, req_ready}, 64'd0);
            @(negedge clk);
            chk(rsp_valid === 1'b1, "R8", "response held", {63'b0, rsp_valid}, 64'd1);
        end
        chk(rsp_fault === e_fault, tag, "fault flag", {63'b0, rsp_fault}, {63'b0, e_fault});
        if (e_fault) begin
            chk(rsp_fault_cause === e_cause, tag, "fault cause", {63'b0, rsp_fault_cause}, {63'b0, e_cause});
            chk(rsp_fault_level === e_lvl, tag, "fault level", {62'b0, rsp_fault_level}, {62'b0, e_lvl});
        end
        chk(rsp_ppn === e_ppn, (tag == "R7") ? "R7/R5" : tag, "ppn", {34'b0, rsp_ppn}, {34'b0, e_ppn});
        chk({rsp_read, rsp_write, rsp_exec} === {e_r, e_w, e_x}, (tag == "R7") ? "R7/R5" : tag,
            "permissions rwx", {61'b0, rsp_read, rsp_write, rsp_exec}, {61'b0, e_r, e_w, e_x});
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rd_count == e_reads, tag, "reads issued", rd_count, e_reads);
    endtask

    function automatic logic [63:0] mk_pte(input logic [29:0] ppn, input logic [3:0] rwxv);
        return {21'h0, ppn, 9'h0, rwxv};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(req_ready === 1'b1, "R1", "req_ready after reset", {63'b0, req_ready}, 64'd1);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
        chk(mem_rd_valid === 1'b0, "R1", "mem_rd_valid after reset", {63'b0, mem_rd_valid}, 64'd0);

        // R2 upper field nonzero: top bit and lowest bit of the field
        run_walk(64'h8000_0000_0000_2000, 43'h100, 64'h1, 64'h1, 64'h1, 64'h1);
        run_walk(64'h0020_0000_0000_0000, 43'h100, 64'h1, 64'h1, 64'h1, 64'h1);

        // R7 full walk with distinct indices
        run_walk(64'h001F_F8A5_5C3E_1ABC, 43'h4_0000_2000,
                 mk_pte(30'h0000_0011, 4'h1), mk_pte(30'h0000_0222, 4'h1),
                 mk_pte(30'h0000_3333, 4'h1), mk_pte(30'h3ABC_DEF1, 4'hB));

        // R6 invalid entry at each level
        for (int k = 0; k < 4; k++) begin
            logic [63:0] p [4];
            for (int l = 0; l < 4; l++) p[l] = mk_pte(30'(l * 7 + 5), (l == k) ? 4'hE : 4'hF);
            run_walk(64'h0012_3456_789A_B000, 43'h7_FFFF_F000, p[0], p[1], p[2], p[3]);
        end

        // R5 reserved bits set everywhere, permission patterns varied
        run_walk(64'h0000_0000_0000_0000, 43'h0,
                 64'hFFFF_FFFF_FFFF_FFF1, 64'hFFFF_FFFF_FFFF_FFF1,
                 64'hFFFF_FFFF_FFFF_FFF1, 64'hFFE0_0000_0000_1FF5);
        run_walk(64'h001F_FFFF_FFFF_FFFF, 43'h7FF_FFFF_FFFF,
                 64'h0000_0000_0000_0009, 64'hFFFF_FFFF_FFFF_E003,
                 64'h001F_FFFF_FFFF_E001, 64'hFFFF_FFFF_FFFF_E00B);

        // random walks
        for (int n = 0; n < 300; n++) begin
            logic [63:0] va, p [4];
            logic [42:0] root;
            va   = {$urandom, $urandom};
            if ($urandom % 8 != 0) va[63:53] = '0;
            root = {$urandom, $urandom};
            for (int l = 0; l < 4; l++) begin
                p[l] = {$urandom, $urandom};
                p[l][0] = ($urandom % 10 != 0);
            end
            run_walk(va, root, p[0], p[1], p[2], p[3]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule